// File: doc/BRIEF.md
# Gated Master-Slave Timer Pair

Two up-counting timers run from one internal clock through one shared prescaler. The master timer produces a trigger signal. A master-mode field picks what drives that signal: a PWM-style compare reference (high while the master count is below a compare value), or the master's own enable bit. The slave timer takes its trigger from a trigger-select field. In gated mode, the slave counts only while that trigger is high and keeps its value while the trigger is low. The slave samples the trigger through one register stage.

Software programs the pair through a write-only register port. For each timer it can set the enable, the mode fields, the auto-reload limit and the compare value. It can write either counter directly. It can fire an update strobe that zeroes a counter and restarts the shared prescaler. When the slave's trigger rises, the slave sets a flag, and the flag stays set until software writes a zero to it.

A typical use: the master is set so that its enable acts as the trigger, and the slave is preloaded with a start value. Enabling the master starts both timers. Disabling it freezes the slave.

Top module: `tmr_gated_pair`

## Requirements
- R1: After reset both counters read 0, the flag reads 0 and the trigger output is low.
- R2: The prescaler value P (address 2) makes both timers advance at most once every P+1 clocks. With P=0 they advance every clock.
- R3: The trigger output follows the master mode in bits [6:4] of address 0. Mode 3'b100 gives master count < compare (address 5). Mode 3'b001 gives the master enable (bit 0 of address 0). Every other mode gives 0.
- R4: Trigger-select 3'b000 (bits [10:8] of address 1) feeds the trigger output to the slave's gate. Any other select value gives a gate that is always low.
- R5: Slave mode 3'b101 (bits [6:4] of address 1) is gated mode. The slave advances on a tick only if the selected trigger was high one clock earlier, and otherwise holds. With any other slave mode the slave counts freely.
- R6: The slave never advances while its enable (bit 0 of address 1) is 0, whatever the gate.
- R7: A counter at its reload value (address 3 for the master, address 4 for the slave) goes to 0 on its next advance.
- R8: Writing address 8 with bit 0 set zeroes the master counter, and with bit 1 set zeroes the slave counter. Either bit also restarts the prescaler. The strobe wins over a counting advance.
- R9: A write to address 6 or address 7 loads the master or slave counter. Counting then continues from the loaded value; for example, 0xE7 is followed by 0xE8 and then 0xE9.
- R10: The flag sets in the clock after the selected trigger rises. Writing address 9 with bit 0 = 0 clears the flag. A rise in the same clock as the clear leaves the flag set.
- R11: Clearing the master enable while the slave is gated by that enable stops the slave within two clocks, and the slave then keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| trig_out_o | output | 1 | Master trigger output |
| cnt_m_o | output | 16 | Master counter |
| cnt_s_o | output | 16 | Slave counter |
| flag_o | output | 1 | Slave trigger flag |

## Verification
The slave's gating is tried with three kinds of trigger. The master's enable as trigger checks start/stop timing and the 0xE7 preload sequence. A compare reference that toggles as the master wraps checks that the slave counts only in the window where the trigger was high one clock earlier. A deselected trigger checks that the gate stays low. Prescaler values above zero separate tick-qualified counting from per-clock counting. Random register writes, mixed with the directed cases, put update strobes, counter loads and flag clears into the same clocks as ticks and trigger edges, which tests the priorities between them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_MCTL = 4'd0;
    localparam logic [ADDR_W-1:0] A_SCTL = 4'd1;
    localparam logic [ADDR_W-1:0] A_PSC  = 4'd2;
    localparam logic [ADDR_W-1:0] A_MARR = 4'd3;
    localparam logic [ADDR_W-1:0] A_SARR = 4'd4;
    localparam logic [ADDR_W-1:0] A_MCMP = 4'd5;
    localparam logic [ADDR_W-1:0] A_MCNT = 4'd6;
    localparam logic [ADDR_W-1:0] A_SCNT = 4'd7;
    localparam logic [ADDR_W-1:0] A_UPD  = 4'd8;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'd9;

    localparam logic [2:0] MM_ENABLE = 3'b001;
    localparam logic [2:0] MM_CMPREF = 3'b100;
    localparam logic [2:0] SM_GATED  = 3'b101;
    localparam logic [2:0] TS_MASTER = 3'b000;

    typedef struct packed {
        logic             m_en;
        logic [2:0]       m_mode;
        logic             s_en;
        logic [2:0]       s_mode;
        logic [2:0]       s_tsel;
        logic [CNT_W-1:0] psc;
        logic [CNT_W-1:0] m_arr;
        logic [CNT_W-1:0] s_arr;
        logic [CNT_W-1:0] m_cmp;
        logic             gate;
        logic             flag;
    } ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] pcnt_d, pcnt_q;

    always_comb begin
        tick = (pcnt_q >= ratio);
        if (restart || tick) pcnt_d = '0;
        else                 pcnt_d = pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R2
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic [W-1:0] arr,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (ld)            cnt_d = ld_val;
        else if (adv)           cnt_d = (cnt_q == arr) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R7
    wrap_at_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !ld && cnt_q == arr) |=> (cnt_q == '0));
    // R8
    strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    // R9
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/tmr_gated_pair.sv
module tmr_gated_pair
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          trig_out_o,
    output logic [CW-1:0] cnt_m_o,
    output logic [CW-1:0] cnt_s_o,
    output logic          flag_o
);
    ctl_t ctl_d, ctl_q;

    logic          tick;
    logic          upd_m, upd_s, ld_m, ld_s;
    logic          trig, sel_trig;
    logic          adv_m, adv_s;
    logic [CW-1:0] cnt_m, cnt_s;

    always_comb begin
        upd_m = wr_en && (wr_addr == A_UPD) && wr_data[0];
        upd_s = wr_en && (wr_addr == A_UPD) && wr_data[1];
        ld_m  = wr_en && (wr_addr == A_MCNT);
        ld_s  = wr_en && (wr_addr == A_SCNT);

        case (ctl_q.m_mode)
            MM_CMPREF: trig = (cnt_m < ctl_q.m_cmp);
            MM_ENABLE: trig = ctl_q.m_en;
            default:   trig = 1'b0;
        endcase
        sel_trig = (ctl_q.s_tsel == TS_MASTER) ? trig : 1'b0;

        adv_m = ctl_q.m_en && tick;
        adv_s = ctl_q.s_en && tick && ((ctl_q.s_mode != SM_GATED) || ctl_q.gate);

        ctl_d      = ctl_q;
        ctl_d.gate = sel_trig;
        if (wr_en) begin
            case (wr_addr)
                A_MCTL: begin
                    ctl_d.m_en   = wr_data[0];
                    ctl_d.m_mode = wr_data[6:4];
                end
                A_SCTL: begin
                    ctl_d.s_en   = wr_data[0];
                    ctl_d.s_mode = wr_data[6:4];
                    ctl_d.s_tsel = wr_data[10:8];
                end
                A_PSC:  ctl_d.psc   = wr_data;
                A_MARR: ctl_d.m_arr = wr_data;
                A_SARR: ctl_d.s_arr = wr_data;
                A_MCMP: ctl_d.m_cmp = wr_data;
                A_FLAG: if (!wr_data[0]) ctl_d.flag = 1'b0;
                default: ;
            endcase
        end
        if (sel_trig && !ctl_q.gate) ctl_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.m_arr <= '1;
            ctl_q.s_arr <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    tmr_prescaler #(.W(CW)) u_psc (
        .clk(clk), .rst_n(rst_n), .ratio(ctl_q.psc),
        .restart(upd_m || upd_s), .tick(tick)
    );

    tmr_counter #(.W(CW)) u_mcnt (
        .clk(clk), .rst_n(rst_n), .clr(upd_m), .ld(ld_m), .ld_val(wr_data),
        .adv(adv_m), .arr(ctl_q.m_arr), .cnt(cnt_m)
    );

    tmr_counter #(.W(CW)) u_scnt (
        .clk(clk), .rst_n(rst_n), .clr(upd_s), .ld(ld_s), .ld_val(wr_data),
        .adv(adv_s), .arr(ctl_q.s_arr), .cnt(cnt_s)
    );

    assign trig_out_o = trig;
    assign cnt_m_o    = cnt_m;
    assign cnt_s_o    = cnt_s;
    assign flag_o     = ctl_q.flag;

    // R5
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.s_mode == SM_GATED && !ctl_q.gate && !upd_s && !ld_s) |=> $stable(cnt_s));
    // R6
    slave_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.s_en && !upd_s && !ld_s) |=> $stable(cnt_s));
    // R10
    flag_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.gate) |-> ctl_q.flag);
    // R4
    deselected_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.s_tsel != TS_MASTER) |=> !ctl_q.gate);
endmodule

// File: tb/sim_tmr_gated_pair.sv
module sim_tmr_gated_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trig_out_o;
    logic [15:0] cnt_m_o, cnt_s_o;
    logic        flag_o;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    tmr_gated_pair u0 (.*);

    // reference state, built from the requirements
    logic        r_men, r_sen, r_gate, r_flag;
    logic [2:0]  r_mm, r_sm, r_ts;
    logic [15:0] r_psc, r_marr, r_sarr, r_cmp, r_pc, r_cm, r_cs;

    function automatic logic f_trig(input logic [2:0] mm, input logic en,
                                    input logic [15:0] cm, input logic [15:0] cmp);
        if (mm == 3'b100) return cm < cmp;
        if (mm == 3'b001) return en;
        return 1'b0;
    endfunction

    function automatic logic [15:0] f_next(input logic [15:0] c, input logic [15:0] arr);
        return (c == arr) ? 16'd0 : c + 16'd1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_men = 0; r_sen = 0; r_gate = 0; r_flag = 0;
            r_mm = 0; r_sm = 0; r_ts = 0; r_psc = 0;
            r_marr = 16'hFFFF; r_sarr = 16'hFFFF; r_cmp = 0;
            r_pc = 0; r_cm = 0; r_cs = 0;
        end else begin
            logic tk, tr, st, um, us, am, as_;
            logic [15:0] ncm, ncs;
            tk  = (r_pc >= r_psc);
            tr  = f_trig(r_mm, r_men, r_cm, r_cmp);
            st  = (r_ts == 3'b000) ? tr : 1'b0;
            um  = wr_en && wr_addr == 4'd8 && wr_data[0];
            us  = wr_en && wr_addr == 4'd8 && wr_data[1];
            am  = r_men && tk;
            as_ = r_sen && tk && (r_sm != 3'b101 || r_gate);
            ncm = um ? 16'd0 : (wr_en && wr_addr == 4'd6) ? wr_data : am ? f_next(r_cm, r_marr) : r_cm;
            ncs = us ? 16'd0 : (wr_en && wr_addr == 4'd7) ? wr_data : as_ ? f_next(r_cs, r_sarr) : r_cs;
            r_pc = (um || us || tk) ? 16'd0 : r_pc + 16'd1;
            if (wr_en && wr_addr == 4'd9 && !wr_data[0]) r_flag = 0;
            if (st && !r_gate) r_flag = 1;
            r_gate = st;
            r_cm = ncm; r_cs = ncs;
            if (wr_en) case (wr_addr)
                4'd0: begin r_men = wr_data[0]; r_mm = wr_data[6:4]; end
                4'd1: begin r_sen = wr_data[0]; r_sm = wr_data[6:4]; r_ts = wr_data[10:8]; end
                4'd2: r_psc  = wr_data;
                4'd3: r_marr = wr_data;
                4'd4: r_sarr = wr_data;
                4'd5: r_cmp  = wr_data;
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (model_on) begin
        chk(cnt_m_o == r_cm, "R2/R7/R8/R9 master model", cnt_m_o, r_cm);
        chk(cnt_s_o == r_cs, "R5/R6/R10 slave model", cnt_s_o, r_cs);
        chk(trig_out_o == f_trig(r_mm, r_men, r_cm, r_cmp), "R3 trigger model",
            trig_out_o, f_trig(r_mm, r_men, r_cm, r_cmp));
        chk(flag_o == r_flag, "R10 flag model", flag_o, r_flag);
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd4242));
        step(2);
        // R1
        chk(cnt_m_o == 0 && cnt_s_o == 0, "R1 counters", {cnt_m_o, cnt_s_o}, 0);
        chk(!flag_o && !trig_out_o, "R1 flag/trigger", {flag_o, trig_out_o}, 0);
        rst_n = 1;
        @(negedge clk);
        model_on = 1;

        // R9 / R10 / R5: master enable gates slave preloaded with 0xE7
        wr(4'd0, 16'h0010);           // master mode enable-as-trigger, off
        wr(4'd1, 16'h0051);           // slave gated, select master, enabled
        wr(4'd8, 16'h0003);
        wr(4'd7, 16'h00E7);
        chk(cnt_s_o == 16'h00E7, "R9 preload", cnt_s_o, 16'hE7);
        wr(4'd0, 16'h0011);           // start master
        chk(cnt_s_o == 16'h00E7 && trig_out_o, "R5 gate latency", cnt_s_o, 16'hE7);
        step(1);
        chk(flag_o == 1'b1, "R10 flag set on rise", flag_o, 1);
        chk(cnt_s_o == 16'h00E7, "R5 one-clock latency", cnt_s_o, 16'hE7);
        step(1);
        chk(cnt_s_o == 16'h00E8, "R9 next E8", cnt_s_o, 16'hE8);
        step(1);
        chk(cnt_s_o == 16'h00E9, "R9 next E9", cnt_s_o, 16'hE9);
        // R11
        wr(4'd0, 16'h0010);
        step(2);
        held = cnt_s_o;
        step(5);
        chk(cnt_s_o == held, "R11 slave holds after master stop", cnt_s_o, held);
        chk(cnt_s_o == 16'h00EB, "R11 stop point", cnt_s_o, 16'hEB);
        // R10 clear
        wr(4'd9, 16'h0000);
        chk(flag_o == 1'b0, "R10 flag cleared", flag_o, 0);

        // R6: slave disabled while gate high
        wr(4'd1, 16'h0050);
        wr(4'd0, 16'h0011);
        held = cnt_s_o;
        step(6);
        chk(cnt_s_o == held, "R6 disabled slave holds", cnt_s_o, held);

        // R4: deselected trigger
        wr(4'd1, 16'h0151);
        held = cnt_s_o;
        step(2);
        held = cnt_s_o;
        step(6);
        chk(cnt_s_o == held, "R4 deselected gate low", cnt_s_o, held);

        // R8 strobe and R7 wrap
        wr(4'd8, 16'h0003);
        chk(cnt_m_o == 0 && cnt_s_o == 0, "R8 strobe zeroes", {cnt_m_o, cnt_s_o}, 0);
        wr(4'd3, 16'd5);
        wr(4'd6, 16'd5);
        chk(cnt_m_o == 16'd5, "R7 at reload", cnt_m_o, 5);
        step(1);
        chk(cnt_m_o == 16'd0, "R7 wrap to 0", cnt_m_o, 0);

        // R2 prescaler ratio 2
        wr(4'd3, 16'hFFFF);
        wr(4'd2, 16'd2);
        wr(4'd8, 16'h0001);
        held = cnt_m_o;
        step(6);
        chk(cnt_m_o == held + 16'd2, "R2 prescale by 3", cnt_m_o, held + 16'd2);

        // R3 compare reference gating the slave
        wr(4'd2, 16'd0);
        wr(4'd3, 16'd9);
        wr(4'd5, 16'd4);
        wr(4'd0, 16'h0041);
        wr(4'd1, 16'h0051);
        step(30);
        chk(trig_out_o == (cnt_m_o < 16'd4), "R3 compare ref", trig_out_o, cnt_m_o < 16'd4);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 19);
            logic [15:0] d = 16'($urandom);
            if (sel < 3)       wr(4'd0, {9'd0, ($urandom_range(0, 3) == 0) ? 3'b000 : (sel[0] ? 3'b100 : 3'b001), 3'd0, d[0] | d[1]});
            else if (sel < 5)  wr(4'd1, {5'd0, ($urandom_range(0, 5) == 0) ? 3'b010 : 3'b000, 1'b0, ($urandom_range(0, 3) == 0) ? 3'b000 : 3'b101, 3'd0, d[0] | d[1]});
            else if (sel == 5) wr(4'd2, 16'($urandom_range(0, 3)));
            else if (sel == 6) wr(4'd3, 16'($urandom_range(2, 40)));
            else if (sel == 7) wr(4'd4, 16'($urandom_range(2, 60)));
            else if (sel == 8) wr(4'd5, 16'($urandom_range(0, 40)));
            else if (sel == 9) wr(4'd6, 16'($urandom_range(0, 50)));
            else if (sel == 10) wr(4'd7, d);
            else if (sel == 11) wr(4'd8, 16'($urandom_range(0, 3)));
            else if (sel == 12) wr(4'd9, 16'(d[0]));
            else step($urandom_range(1, 6));
        end
        step(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule